// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator with Committed Settings

This block drives one pulse-width modulated output from a fixed reference clock. A prescaler divides the reference clock into ticks. A period counter counts those ticks. The output goes high at the start of each period and stays high for a programmed number of ticks. Both the prescaler and the period divider are stored as the wanted count minus one, so one period lasts `(prescaler + 1) * (divider + 1)` reference cycles.

Software sets the block through a plain register port with two 32-bit words. Word 0 carries the high-time and divider fields. Word 1 carries the prescaler, an enable flag and a commit flag. Writes only fill holding registers. A word-1 write that has the commit flag set moves all fields and the enable flag into the running set in one step, so one period never mixes old and new values. While the channel runs, the committed set waits for the end of the current period. While the channel is stopped, it takes effect at once. Reads return the running set. The write and read ports have no handshake: a write is taken on every clock edge where `wr_en` is high, and `rd_data` follows `rd_addr` with no delay.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset the output is low, the channel is disabled, and both words read back as zero.
- R2: One period lasts (prescaler + 1) * (divider + 1) reference clock cycles. Each field is 16 bits wide.
- R3: The output is high for high_time * (prescaler + 1) cycles from the start of each period. If high_time is greater than the divider, the output is always high. With divider = 0xFFFF and high_time = 0xFFFF, the output is high for 65535 of 65536 cycles.
- R4: A word-0 write, or a word-1 write with bit 17 clear, changes neither the output nor the read-back values.
- R5: A word-1 write with bit 17 set commits the whole configuration: high_time and divider from the last word-0 write, plus the prescaler and enable carried in that write. If the channel was disabled, the new set applies on the next clock edge. If it was enabled, the running period ends with the old values and the new set starts at the next period boundary.
- R6: Enable (word 1 bit 16) only takes effect through a commit write. While the channel is disabled, the output is low.
- R7: With high_time = 0, the output stays low for the whole period.
- R8: Field layout for writes and reads: word 0 is {divider[31:16], high_time[15:0]}, and word 1 is {commit[17], enable[16], prescaler[15:0]}. Reads return the running values, and bit 17 of word 1 always reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, taken on the clock edge |
| wr_addr | input | 1 | Word select for writes (0 or 1) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Word select for reads |
| rd_data | output | 32 | Running configuration of the selected word |
| pwm_o | output | 1 | Modulated output |

## Verification
The assertions check these rules on every cycle:
- Both counters stay inside their programmed limits.
- The running set never changes in the middle of a period.
- A write without the commit flag leaves the running set untouched.
- The output is low whenever the channel is disabled or high_time is zero.
- The output is high whenever high_time is greater than the divider.

Some behaviour shows only in the bench's measured waveforms:
- The exact period and high-time lengths in reference cycles.
- That an interrupted period finishes with its old lengths.
- That a commit from the disabled state starts the output on the next edge.
- The lengths at the largest divider value.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int unsigned FIELD_W = 16;
  localparam int unsigned WORD_W  = 2 * FIELD_W;
  localparam int unsigned EN_BIT  = FIELD_W;
  localparam int unsigned UPD_BIT = FIELD_W + 1;

  typedef struct packed {
    logic               en;
    logic [FIELD_W-1:0] pre;
    logic [FIELD_W-1:0] div;
    logic [FIELD_W-1:0] hi;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              period_end,
  output pwm_cfg_t          act_o
);
  logic [FIELD_W-1:0] hold_hi_q, hold_div_q;
  pwm_cfg_t           stage_q, act_q, commit_cfg;
  logic               pend_q;
  logic               commit_wr;
  logic               unused_upper;

  assign commit_wr    = wr_en & wr_addr & wr_data[UPD_BIT];
  assign unused_upper = ^wr_data[WORD_W-1:UPD_BIT+1];

  // Full set formed by a commit write: word-0 holding values plus this write's word 1
  always_comb begin
    commit_cfg.en  = wr_data[EN_BIT];
    commit_cfg.pre = wr_data[FIELD_W-1:0];
    commit_cfg.div = hold_div_q;
    commit_cfg.hi  = hold_hi_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_hi_q  <= '0;
      hold_div_q <= '0;
      stage_q    <= '0;
      act_q      <= '0;
      pend_q     <= 1'b0;
    end else begin
      if (wr_en && !wr_addr) begin
        hold_hi_q  <= wr_data[FIELD_W-1:0];
        hold_div_q <= wr_data[WORD_W-1:FIELD_W];
      end
      if (commit_wr) begin
        if (!act_q.en || period_end) begin
          act_q  <= commit_cfg;
          pend_q <= 1'b0;
        end else begin
          stage_q <= commit_cfg;
          pend_q  <= 1'b1;
        end
      end else if (pend_q && period_end) begin
        act_q  <= stage_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign act_o = act_q;

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.en && !period_end) |=> $stable(act_q)); // R5
  AST_PLAIN_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !commit_wr && !pend_q) |=> $stable(act_q)); // R4
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [FIELD_W-1:0] pre,
  output logic               tick_o
);
  logic [FIELD_W-1:0] pc_q;

  assign tick_o = en && (pc_q >= pre);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) pc_q <= '0;
    else if (tick_o)   pc_q <= '0;
    else               pc_q <= pc_q + 1'b1;
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (pc_q <= pre)); // R2
endmodule

// File: rtl/pwm_period.sv
module pwm_period
  import pwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic [FIELD_W-1:0] div,
  input  logic [FIELD_W-1:0] hi,
  output logic               period_end_o,
  output logic               pwm_o
);
  logic [FIELD_W-1:0] cnt_q;

  assign period_end_o = tick && (cnt_q >= div);
  assign pwm_o        = en && (cnt_q < hi);

  always_ff @(posedge clk) begin
    if (!rst_n || !en)  cnt_q <= '0;
    else if (tick) begin
      if (period_end_o) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= div)); // R2
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              pwm_o
);
  localparam int unsigned PAD_W = WORD_W - UPD_BIT;

  pwm_cfg_t act;
  logic     tick, period_end;

  pwm_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period_end(period_end), .act_o(act)
  );

  pwm_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .en(act.en), .pre(act.pre), .tick_o(tick)
  );

  pwm_period u_per (
    .clk(clk), .rst_n(rst_n), .en(act.en), .tick(tick),
    .div(act.div), .hi(act.hi), .period_end_o(period_end), .pwm_o(pwm_o)
  );

  // Commit flag reads as zero; upper bits padded with zeros
  assign rd_data = rd_addr ? {{PAD_W{1'b0}}, act.en, act.pre} : {act.div, act.hi};

  AST_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !act.en |-> !pwm_o); // R6
  AST_ZERO_HIGH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act.hi == '0) |-> !pwm_o); // R7
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (act.en && (act.hi > act.div)) |-> pwm_o); // R3
endmodule

// File: tb/pwm_prescaled_tb.sv
module pwm_prescaled_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_o;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pwm_prescaled u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_o(pwm_o)
  );

  function automatic longint exp_period(int pre, int div);
    return longint'(pre + 1) * longint'(div + 1);
  endfunction
  function automatic longint exp_high(int pre, int div, int hi);
    if (hi > div) return exp_period(pre, div);
    return longint'(hi) * longint'(pre + 1);
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr0(int hi, int div);
    @(negedge clk); wr_en = 1'b1; wr_addr = 1'b0; wr_data = {div[15:0], hi[15:0]};
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic wr1(int pre, bit en, bit upd);
    @(negedge clk); wr_en = 1'b1; wr_addr = 1'b1;
    wr_data = {14'b0, upd, en, pre[15:0]};
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(bit a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_rise();
    bit pv = pwm_o;
    for (int i = 0; i < 140000; i++) begin
      @(negedge clk);
      if (pwm_o && !pv) return;
      pv = pwm_o;
    end
  endtask
  // Called on the first high sample of a period; returns on the next period's first sample
  task automatic count_period(output int hi_n, output int per_n);
    bit pv = 1'b1;
    hi_n = 1; per_n = 1;
    forever begin
      @(negedge clk);
      if (pwm_o && !pv) break;
      if (pwm_o) hi_n++;
      pv = pwm_o;
      per_n++;
      if (per_n > 140000) break;
    end
  endtask
  task automatic count_high(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm_o) h++; end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h, p, pre, div, hi;
    void'($urandom(32'd20210716));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "pwm after reset", pwm_o, 0);
    rd(0, d); check("R1", "word0 after reset", d, 0);
    rd(1, d); check("R1", "word1 after reset", d, 0);

    // R6 enable without commit is ignored
    wr0(2, 4);
    wr1(0, 1'b1, 1'b0);
    count_high(30, h); check("R6", "highs after plain enable", h, 0);
    rd(1, d); check("R6", "enable readback w/o commit", d[16], 0);

    // R5 immediate commit from disabled; R2/R3 lengths
    wr1(0, 1'b1, 1'b1);
    check("R5", "output high next edge after commit", pwm_o, 1);
    count_period(h, p);
    check("R2", "period pre0 div4", p, exp_period(0, 4));
    check("R3", "high pre0 hi2", h, exp_high(0, 4, 2));
    rd(0, d); check("R8", "word0 readback", d, {16'd4, 16'd2});
    rd(1, d); check("R8", "word1 readback commit bit clear", d, 32'h0001_0000);

    // R4 plain writes while running change nothing
    wr0(5, 9);
    wr1(3, 1'b1, 1'b0);
    wait_rise(); count_period(h, p);
    check("R4", "period after plain writes", p, exp_period(0, 4));
    check("R4", "high after plain writes", h, exp_high(0, 4, 2));
    rd(0, d); check("R4", "word0 after plain writes", d, {16'd4, 16'd2});
    rd(1, d); check("R4", "word1 after plain writes", d, 32'h0001_0000);

    // Random configurations, committed while running
    for (int k = 0; k < 10; k++) begin
      pre = $urandom_range(0, 4);
      div = $urandom_range(1, 12);
      hi  = $urandom_range(1, div);
      wr0(hi, div);
      wr1(pre, 1'b1, 1'b1);
      wait_rise(); count_period(h, p);
      check("R2", "random period", p, exp_period(pre, div));
      check("R3", "random high", h, exp_high(pre, div, hi));
      rd(0, d); check("R8", "random word0", d, {div[15:0], hi[15:0]});
      rd(1, d); check("R8", "random word1", d, {15'b0, 1'b1, pre[15:0]});
    end

    // R7 zero high time
    wr0(0, 3); wr1(0, 1'b1, 1'b1);
    repeat (80) @(negedge clk);
    count_high(40, h); check("R7", "highs with hi=0", h, 0);

    // R3 high time above divider: always high
    wr0(7, 3); wr1(1, 1'b1, 1'b1);
    repeat (80) @(negedge clk);
    count_high(40, h); check("R3", "highs with hi>div", h, 40);

    // R6 disable through commit; output low
    wr1(0, 1'b0, 1'b1);
    repeat (80) @(negedge clk);
    count_high(40, h); check("R6", "highs when disabled", h, 0);
    rd(1, d); check("R6", "enable readback after disable", d[16], 0);

    // R5 running period completes with old values
    wr0(10, 19); wr1(0, 1'b1, 1'b1);
    wr0(1, 3);
    wait_rise();
    begin
      bit pv = 1'b1;
      h = 1; p = 1;
      forever begin
        @(negedge clk);
        wr_en = 1'b0;
        if (pwm_o && !pv) break;
        if (pwm_o) h++;
        pv = pwm_o;
        p++;
        if (p == 3) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = {14'b0, 1'b1, 1'b1, 16'd0}; end
        if (p > 1000) break;
      end
    end
    check("R5", "interrupted period length old", p, 20);
    check("R5", "interrupted high old", h, 10);
    count_period(h, p);
    check("R5", "next period new", p, exp_period(0, 3));
    check("R5", "next high new", h, exp_high(0, 3, 1));

    // R3 largest divider cannot reach full duty
    wr1(0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    wr0(16'hFFFF, 16'hFFFF);
    wr1(0, 1'b1, 1'b1);
    check("R5", "immediate start at max divider", pwm_o, 1);
    count_period(h, p);
    check("R2", "period at max divider", p, 65536);
    check("R3", "high at max divider", h, 65535);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule